// File: doc/BRIEF.md
# Carry-Select Adder with Excess-One Converters

This block adds two 32-bit operands and a carry input, giving a 32-bit sum and a carry output. It has no clock and no state. The operand bits are divided into sections of unequal width. The lowest section is an ordinary ripple-carry adder that takes the external carry directly.

Each higher section builds only one ripple result, which assumes that no carry enters it. That result, with its own carry-out bit appended, goes through an incrementer. The incrementer gives the result the section would have if a carry did enter it. A two-way multiplexer then picks either the plain result or the incremented one. The select line is the carry actually produced by the section below. This removes the second ripple adder that a classic carry-select design needs for each section.

The block drops straight into a datapath as pure logic. The result is valid in the same cycle as the operands.

Top module: `csx_adder`

## Requirements
- R1: For every a, b and cin, the concatenation {cout, sum} equals a + b + cin computed at 33 bits.
- R2: By default there are seven sections, 2, 2, 3, 4, 5, 6 and 10 bits wide from least to most significant, with boundaries at bit 2, 4, 7, 11, 16 and 22. The carry leaving each section equals the true carry out of the addition of all bits up to and including that section.
- R3: When a higher section's carry-free sum is all ones and a carry arrives from below, the section's sum bits wrap to zero and it passes a carry of one upward. Example: 0x0000000F + 0x00000001 gives 0x00000010.
- R4: The lowest section uses cin directly, so sum[0] equals a[0] XOR b[0] XOR cin.
- R5: A carry that travels through every section is resolved. All-ones plus zero with cin = 1, and all-ones plus one with cin = 0, both give sum = 0 and cout = 1.
- R6: Zero plus zero with cin = 0 gives sum = 0 and cout = 0.
- R7: The alternating patterns 0xAAAAAAAA and 0x55555555 give 0xFFFFFFFF with cout = 0 when cin = 0, and 0x00000000 with cout = 1 when cin = 1.
- R8: The outputs depend only on the current inputs. There is no register, and a new input is reflected at the outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 32 | Sum bits |
| cout | output | 1 | Carry out of bit 31 |

## Verification
Every result of this adder is due zero cycles after its operands change, because no register lies on any path. The bench changes the operands on a falling clock edge and samples sum and cout one nanosecond after the next rising edge. Each sample therefore sees settled logic and cannot pick up a value from an earlier vector. A separate check drives new operands and reads the outputs one nanosecond later with no clock edge in between, to show that the result does not wait for a clock.

// File: rtl/csx_pkg.sv
package csx_pkg;
  localparam int unsigned CSX_WIDTH = 32;
  localparam int unsigned CSX_NSEC  = 7;
  typedef int unsigned csx_secw_t [CSX_NSEC];
  localparam csx_secw_t CSX_SEC_W = '{2, 2, 3, 4, 5, 6, 10};
endpackage

// File: rtl/csx_ripple.sv
module csx_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = ci;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]   = x[i] ^ y[i] ^ c[i];
    assign c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
  end
  assign co = c[W];
endmodule

// File: rtl/csx_inc.sv
module csx_inc #(
  parameter int unsigned W = 5
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // ones_below[i] is high when every bit under position i is set
  logic [W-1:0] ones_below;
  assign ones_below[0] = 1'b1;
  for (genvar i = 1; i < W; i++) begin : g_and
    assign ones_below[i] = ones_below[i-1] & d[i-1];
  end
  assign q = d ^ ones_below;
endmodule

// File: rtl/csx_section.sv
module csx_section #(
  parameter int unsigned W     = 4,
  parameter bit          FIRST = 1'b0
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  if (FIRST) begin : g_plain
    csx_ripple #(.W(W)) u_rca (.x(x), .y(y), .ci(ci), .s(s), .co(co));
  end else begin : g_select
    logic [W-1:0] s_zero;
    logic         c_zero;
    logic [W:0]   bumped;
    csx_ripple #(.W(W)) u_rca (.x(x), .y(y), .ci(1'b0), .s(s_zero), .co(c_zero));
    csx_inc #(.W(W+1)) u_inc (.d({c_zero, s_zero}), .q(bumped));
    assign {co, s} = ci ? bumped : {c_zero, s_zero};
  end
endmodule

// File: rtl/csx_adder.sv
module csx_adder
  import csx_pkg::*;
#(
  parameter int unsigned WIDTH = CSX_WIDTH,
  parameter csx_secw_t   SEC_W = CSX_SEC_W
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  function automatic int unsigned lo_of(input int unsigned k);
    int unsigned acc = 0;
    for (int unsigned i = 0; i < k; i++) acc += SEC_W[i];
    return acc;
  endfunction

  // carry leaving each section; sec_cy[k] feeds section k+1
  logic [CSX_NSEC-1:0] sec_cy;

  for (genvar k = 0; k < CSX_NSEC; k++) begin : g_sec
    localparam int unsigned LO = lo_of(k);
    localparam int unsigned SW = SEC_W[k];
    logic carry_in;
    if (k == 0) begin : g_c0
      assign carry_in = cin;
    end else begin : g_cn
      assign carry_in = sec_cy[k-1];
    end
    csx_section #(.W(SW), .FIRST(k == 0)) u_sec (
      .x (a[LO +: SW]),
      .y (b[LO +: SW]),
      .ci(carry_in),
      .s (sum[LO +: SW]),
      .co(sec_cy[k])
    );
  end

  assign cout = sec_cy[CSX_NSEC-1];
endmodule

// File: rtl/csx_adder_chk.sv
module csx_adder_chk
  import csx_pkg::*;
#(
  parameter int unsigned WIDTH = CSX_WIDTH,
  parameter csx_secw_t   SEC_W = CSX_SEC_W
) (
  input logic [WIDTH-1:0]    a,
  input logic [WIDTH-1:0]    b,
  input logic                cin,
  input logic [WIDTH-1:0]    sum,
  input logic                cout,
  input logic [CSX_NSEC-1:0] sec_cy
);
  function automatic int unsigned hi_of(input int unsigned k);
    int unsigned acc = 0;
    for (int unsigned i = 0; i <= k; i++) acc += SEC_W[i];
    return acc;
  endfunction

  function automatic logic prefix_carry(input int unsigned hi);
    logic [WIDTH:0] m;
    logic [WIDTH:0] r;
    m = ({{WIDTH{1'b0}}, 1'b1} << hi) - 1'b1;
    r = ({1'b0, a} & m) + ({1'b0, b} & m) + {{WIDTH{1'b0}}, cin};
    return r[hi];
  endfunction

  always_comb begin
    AST_SUM_EXACT: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})); // R1
    AST_LSB_USES_CIN: assert (sum[0] == (a[0] ^ b[0] ^ cin)); // R4
    AST_FULL_RIPPLE: assert (!(cin && ((a ^ b) == '1) && ((a & b) == '0)) || (sum == '0 && cout)); // R5
    AST_ZERO_IN_ZERO_OUT: assert (!(a == '0 && b == '0 && !cin) || (sum == '0 && !cout)); // R6
    for (int unsigned k = 0; k < CSX_NSEC; k++) begin
      AST_SECTION_CARRY: assert (sec_cy[k] == prefix_carry(hi_of(k))); // R2
    end
  end
endmodule

bind csx_adder csx_adder_chk #(.WIDTH(WIDTH), .SEC_W(SEC_W)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout), .sec_cy(sec_cy)
);

// File: tb/csx_adder_tb.sv
module csx_adder_tb;
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        ci;
    logic [32:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{32'h00000000, 32'h00000000, 1'b0, 33'h000000000}, // R6
    '{32'hFFFFFFFF, 32'h00000001, 1'b0, 33'h100000000}, // R5
    '{32'hFFFFFFFF, 32'h00000000, 1'b1, 33'h100000000}, // R5
    '{32'hAAAAAAAA, 32'h55555555, 1'b0, 33'h0FFFFFFFF}, // R7
    '{32'hAAAAAAAA, 32'h55555555, 1'b1, 33'h100000000}, // R7
    '{32'h12345678, 32'h87654321, 1'b0, 33'h099999999}, // R1
    '{32'h80000000, 32'h80000000, 1'b1, 33'h100000001}, // R1
    '{32'h00000003, 32'h00000001, 1'b0, 33'h000000004}, // R2
    '{32'h0000000F, 32'h00000001, 1'b0, 33'h000000010}, // R3
    '{32'h7FFFFFFF, 32'h00000001, 1'b0, 33'h080000000}, // R2
    '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 33'h1FFFFFFFF}, // R1
    '{32'h0003FFFF, 32'h00000000, 1'b1, 33'h000040000}  // R3
  };

  logic        clk = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [31:0] sum;
  logic        cout;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csx_adder u_dut (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  task automatic chk(input string tag, input logic [32:0] got, input logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] va, input logic [31:0] vb, input logic vc);
    @(negedge clk);
    a = va; b = vb; cin = vc;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1;
    chk("R6 idle inputs", {cout, sum}, 33'h0);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i].a, TBL[i].b, TBL[i].ci);
      chk($sformatf("R1 table row %0d", i), {cout, sum}, TBL[i].exp);
    end

    apply(32'h00000000, 32'h00000000, 1'b1);
    chk("R4 cin reaches bit 0", {cout, sum}, 33'h000000001);
    apply(32'h00000001, 32'h00000000, 1'b1);
    chk("R4 cin plus a0", {cout, sum}, 33'h000000002);
    apply(32'hFFFFFFFF, 32'h00000000, 1'b1);
    chk("R5 full ripple", {cout, sum}, 33'h100000000);
    apply(32'h55555555, 32'hAAAAAAAA, 1'b1);
    chk("R7 swapped alternating cin 1", {cout, sum}, 33'h100000000);
    apply(32'h000007FF, 32'h00000001, 1'b0);
    chk("R3 wrap across boundary 11", {cout, sum}, 33'h000000800);
    apply(32'h003FFFFF, 32'h00000000, 1'b1);
    chk("R2 carry into top section", {cout, sum}, 33'h000400000);

    @(negedge clk);
    a = 32'h0000FFFF; b = 32'h00000001; cin = 1'b0;
    #1;
    chk("R8 same cycle result", {cout, sum}, 33'h000010000);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rb;
      logic        rc;
      ra = $urandom; rb = $urandom; rc = 1'($urandom);
      apply(ra, rb, rc);
      chk("R1 random", {cout, sum}, {1'b0, ra} + {1'b0, rb} + {32'b0, rc});
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule